// File: doc/BRIEF.md
# PCI Configuration Cycle Address Translator

This block sits between the processor side of a host-to-PCI bridge and the PCI initiator. It holds a 32-bit configuration target register. For each processor access that reaches an initiator window, it decides which kind of PCI transaction the access becomes. It then produces the PCI command code, the address-phase value on AD[31:0] and the active-low byte enables C/BE[3:0].

For an access to an I/O-type window, the outcome depends on three things: the register's enable bit, whether the device field holds the reserved value 31, and whether the bus field is zero. The possible outcomes are:

- a Type 0 configuration cycle for the local bus;
- a Type 1 configuration cycle for a bus further down;
- an interrupt-acknowledge or special cycle;
- a plain I/O transaction at the window-translated address.

Accesses to memory-type windows are never translated.

A two-state machine (IDLE, PEND) accepts one request and registers the decision. It presents the decision with a valid/ready handshake. Transition IDLE→PEND happens on `req_valid && req_ready`. Transition PEND→IDLE happens on `out_valid && out_ready`. Register writes made while a decision is pending apply only to the next request.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset the enable bit is clear, `out_valid` is 0 and `req_ready` is 1, so a first I/O-window access passes through as I/O.
- R2: Only a write with `reg_wr_addr` = 0x1F8 updates the register. Its layout is: enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:2. Writes to any other offset leave the register unchanged.
- R3: A memory-window access (`req_io_win`=0) gives kind 0 and command 4'b0110 (read) or 4'b0111 (write), with AD = `req_addr`, whatever the register holds.
- R4: An I/O-window access with the enable bit clear gives kind 1 and command 4'b0010 (read) or 4'b0011 (write), with AD = `req_addr`.
- R5: With enable set, device ≠ 31 and bus = 0, the result is kind 2 and command 4'b1010 (read) or 4'b1011 (write). The address phase is laid out as follows:
  - AD[31:11] has only bit 11+device set when device < 21, and is all zero otherwise;
  - AD[10:8] = function;
  - AD[7:2] = register;
  - AD[1:0] = 00.
- R6: With enable set, device ≠ 31 and bus ≠ 0, the result is kind 3 and command 4'b1010/4'b1011. The address phase is AD[31:24]=0, AD[23:16]=bus, AD[15:11]=device, AD[10:8]=function, AD[7:2]=register, AD[1:0]=01.
- R7: With enable set and device = 31, the result is kind 4 and AD = 0. The command is 4'b0000 (interrupt acknowledge) for a read and 4'b0001 (special cycle) for a write.
- R8: `out_cbe_n` is active low and uses lane = address bits [1:0]:
  - size 0 enables the one lane `req_addr[1:0]`;
  - size 1 enables lanes {`req_addr[1]`,0} and {`req_addr[1]`,1};
  - sizes 2 and 3 enable all four lanes.
- R9: `req_ready` is high only in IDLE. An accepted request shows `out_valid` on the next cycle. While `out_ready` is low, `out_valid` and the outputs hold stable. The cycle after `out_ready` is seen, `out_valid` is low and `req_ready` is high.
- R10: A register write made while a decision is pending does not change the pending outputs and applies to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Local register offset |
| reg_wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Window access request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_io_win | input | 1 | Hit window is programmed as I/O space |
| req_addr | input | 32 | Window-translated access address |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | PCI initiator takes the decision |
| out_kind | output | 3 | 0 mem, 1 I/O, 2 Type 0, 3 Type 1, 4 special/int-ack |
| out_cmd | output | 4 | PCI command code |
| out_ad | output | 32 | Address-phase value |
| out_cbe_n | output | 4 | Active-low data-phase byte enables |

## Verification
The bench targets the decision boundaries. These are device 31 against device 30, bus 0 against bus 1, and device 20 against device 21 for the IDSEL range, along with an enable-clear register that still carries a valid-looking target.

A design that tested the wrong device value would issue a configuration cycle where a special cycle belongs. A design with a misplaced IDSEL shift would put a stray or missing bit in the upper AD bits. A register decoded at the wrong offset would flip accesses to configuration cycles.

Back-pressure and a register write during PEND catch a decision that is recomputed combinationally rather than held.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;

    typedef enum logic [2:0] {
        KIND_MEM  = 3'd0,
        KIND_IO   = 3'd1,
        KIND_CFG0 = 3'd2,
        KIND_CFG1 = 3'd3,
        KIND_SPEC = 3'd4
    } xfer_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } xlate_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] regno;
    } cfg_target_t;

    localparam logic [3:0] CMD_INTACK  = 4'b0000;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;
    localparam logic [3:0] CMD_IORD    = 4'b0010;
    localparam logic [3:0] CMD_IOWR    = 4'b0011;
    localparam logic [3:0] CMD_MEMRD   = 4'b0110;
    localparam logic [3:0] CMD_MEMWR   = 4'b0111;
    localparam logic [3:0] CMD_CFGRD   = 4'b1010;
    localparam logic [3:0] CMD_CFGWR   = 4'b1011;

    localparam logic [4:0] DEV_RESERVED = 5'h1F;
    localparam int         IDSEL_LSB    = 11;
    localparam int         IDSEL_BITS   = 32 - IDSEL_LSB;

endpackage

// File: rtl/pci_car_reg.sv
module pci_car_reg
    import pci_xlate_pkg::*;
#(
    parameter int             ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 12'h1F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output cfg_target_t       target
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
        end else if (wr_en && wr_addr == OFFSET) begin
            target.en    <= wr_data[31];
            target.bus   <= wr_data[23:16];
            target.dev   <= wr_data[15:11];
            target.func  <= wr_data[10:8];
            target.regno <= wr_data[7:2];
        end
    end

endmodule

// File: rtl/pci_cycle_decode.sv
module pci_cycle_decode
    import pci_xlate_pkg::*;
(
    input  cfg_target_t target,
    input  logic        is_write,
    input  logic        io_win,
    input  logic [31:0] addr,
    output xfer_kind_e  kind,
    output logic [3:0]  cmd,
    output logic [31:0] ad
);

    logic [IDSEL_BITS-1:0] idsel;

    always_comb begin
        if (target.dev < 5'(IDSEL_BITS))
            idsel = IDSEL_BITS'(1) << target.dev;
        else
            idsel = '0;
    end

    always_comb begin
        if (!io_win)
            kind = KIND_MEM;
        else if (!target.en)
            kind = KIND_IO;
        else if (target.dev == DEV_RESERVED)
            kind = KIND_SPEC;
        else if (target.bus == 8'h00)
            kind = KIND_CFG0;
        else
            kind = KIND_CFG1;
    end

    always_comb begin
        unique case (kind)
            KIND_MEM: begin
                cmd = is_write ? CMD_MEMWR : CMD_MEMRD;
                ad  = addr;
            end
            KIND_IO: begin
                cmd = is_write ? CMD_IOWR : CMD_IORD;
                ad  = addr;
            end
            KIND_CFG0: begin
                cmd = is_write ? CMD_CFGWR : CMD_CFGRD;
                ad  = {idsel, target.func, target.regno, 2'b00};
            end
            KIND_CFG1: begin
                cmd = is_write ? CMD_CFGWR : CMD_CFGRD;
                ad  = {8'h00, target.bus, target.dev, target.func,
                       target.regno, 2'b01};
            end
            default: begin
                cmd = is_write ? CMD_SPECIAL : CMD_INTACK;
                ad  = '0;
            end
        endcase
    end

endmodule

// File: rtl/pci_lane_enable.sv
module pci_lane_enable #(
    parameter int LANES = 4,
    localparam int LSEL_W = $clog2(LANES)
) (
    input  logic [1:0]        size,
    input  logic [LSEL_W-1:0] lane,
    output logic [LANES-1:0]  be_n
);

    logic [LANES-1:0] be;

    always_comb begin
        be = '0;
        for (int i = 0; i < LANES; i++) begin
            unique case (size)
                2'd0:    be[i] = (LSEL_W'(i) == lane);
                2'd1:    be[i] = (LSEL_W'(i) >> 1) == (lane >> 1);
                default: be[i] = 1'b1;
            endcase
        end
        be_n = ~be;
    end

endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
    import pci_xlate_pkg::*;
#(
    parameter int                REG_ADDR_W = 12,
    parameter logic [REG_ADDR_W-1:0] CAR_OFFSET = 12'h1F8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_wr_addr,
    input  logic [31:0]           reg_wr_data,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_io_win,
    input  logic [31:0]           req_addr,
    input  logic [1:0]            req_size,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [2:0]            out_kind,
    output logic [3:0]            out_cmd,
    output logic [31:0]           out_ad,
    output logic [3:0]            out_cbe_n
);

    cfg_target_t  target;
    xfer_kind_e   dec_kind;
    logic [3:0]   dec_cmd;
    logic [31:0]  dec_ad;
    logic [3:0]   dec_be_n;
    xlate_state_e state, state_nx;
    logic         accept;

    pci_car_reg #(.ADDR_W(REG_ADDR_W), .OFFSET(CAR_OFFSET)) car_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .target  (target)
    );

    pci_cycle_decode dec_i (
        .target   (target),
        .is_write (req_write),
        .io_win   (req_io_win),
        .addr     (req_addr),
        .kind     (dec_kind),
        .cmd      (dec_cmd),
        .ad       (dec_ad)
    );

    pci_lane_enable #(.LANES(4)) lane_i (
        .size (req_size),
        .lane (req_addr[1:0]),
        .be_n (dec_be_n)
    );

    assign req_ready = (state == ST_IDLE);
    assign out_valid = (state == ST_PEND);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nx = ST_PEND;
            ST_PEND: if (out_ready) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_kind  <= 3'd0;
            out_cmd   <= 4'd0;
            out_ad    <= '0;
            out_cbe_n <= 4'hF;
        end else if (accept) begin
            out_kind  <= dec_kind;
            out_cmd   <= dec_cmd;
            out_ad    <= dec_ad;
            out_cbe_n <= dec_be_n;
        end
    end

endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [2:0]  out_kind,
    input logic [3:0]  out_cmd,
    input logic [31:0] out_ad,
    input logic [3:0]  out_cbe_n
);

    assert_accept_gives_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid && !req_ready);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ad) && $stable(out_cmd)
                                    && $stable(out_cbe_n) && $stable(out_kind));

    assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && req_ready);

    assert_type0_idsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd2 |-> $onehot0(out_ad[31:11]) && out_ad[1:0] == 2'b00
                                          && out_cmd[3:1] == 3'b101);

    assert_type1_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd3 |-> out_ad[1:0] == 2'b01 && out_ad[31:24] == 8'h00);

    assert_special_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd4 |-> out_cmd[3:1] == 3'b000 && out_ad == 32'h0);

    assert_lane_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(~out_cbe_n) == 1 || $countones(~out_cbe_n) == 2
                       || $countones(~out_cbe_n) == 4));

endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_cmd   (out_cmd),
    .out_ad    (out_ad),
    .out_cbe_n (out_cbe_n)
);

// File: tb/pci_cfg_xlate_tb_top.sv
module pci_cfg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_io_win = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_kind;
    logic [3:0]  out_cmd;
    logic [31:0] out_ad;
    logic [3:0]  out_cbe_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pci_cfg_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_io_win(req_io_win), .req_addr(req_addr), .req_size(req_size),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_cmd(out_cmd), .out_ad(out_ad), .out_cbe_n(out_cbe_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] car(input bit en, input logic [7:0] bus,
                                        input logic [4:0] dev, input logic [2:0] fn,
                                        input logic [5:0] rg);
        return {en, 7'h0, bus, dev, fn, rg, 2'b11};
    endfunction

    function automatic logic [3:0] exp_be_n(input logic [1:0] sz, input logic [1:0] a);
        logic [3:0] be;
        if (sz == 2'd0)      be = 4'b0001 << a;
        else if (sz == 2'd1) be = a[1] ? 4'b1100 : 4'b0011;
        else                 be = 4'b1111;
        return ~be;
    endfunction

    // issue a request, leave it pending; outputs sampled at the following negedge
    task automatic issue(input bit wr, input bit io, input logic [31:0] a, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_io_win = io; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic release_out();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [2:0] k, input logic [3:0] c,
                              input logic [31:0] ad, input logic [3:0] be_n);
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " kind"},  64'(out_kind),  64'(k));
        check({tag, " cmd"},   64'(out_cmd),   64'(c));
        check({tag, " ad"},    64'(out_ad),    64'(ad));
        check({tag, " cbe_n"}, 64'(out_cbe_n), 64'(be_n));
    endtask

    function automatic logic [31:0] type0_ad(input logic [4:0] dev, input logic [2:0] fn,
                                             input logic [5:0] rg);
        logic [31:0] ad = 32'h0;
        if (dev < 21) ad[11 + dev] = 1'b1;
        ad[10:8] = fn;
        ad[7:2]  = rg;
        return ad;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        issue(1'b0, 1'b1, 32'h0000_1234, 2'd2);
        expect_out("R1 io passthrough", 3'd1, 4'b0010, 32'h0000_1234, 4'b0000);
        release_out();
        check("R9 idle after release", 64'({out_valid, req_ready}), 64'b01);
    endtask

    task automatic t_memory();
        write_reg(12'h1F8, car(1'b1, 8'h00, 5'd3, 3'd1, 6'd4));
        issue(1'b0, 1'b0, 32'h8000_0010, 2'd2);
        expect_out("R3 mem read", 3'd0, 4'b0110, 32'h8000_0010, 4'b0000);
        release_out();
        issue(1'b1, 1'b0, 32'h8000_0022, 2'd1);
        expect_out("R3 mem write", 3'd0, 4'b0111, 32'h8000_0022, exp_be_n(2'd1, 2'd2));
        release_out();
    endtask

    task automatic t_io_disabled();
        write_reg(12'h1F8, car(1'b0, 8'h05, 5'd3, 3'd1, 6'd4));
        issue(1'b1, 1'b1, 32'h0000_0C01, 2'd0);
        expect_out("R4 io write", 3'd1, 4'b0011, 32'h0000_0C01, exp_be_n(2'd0, 2'd1));
        release_out();
    endtask

    task automatic t_type0(input logic [4:0] dev, input bit wr);
        write_reg(12'h1F8, car(1'b1, 8'h00, dev, 3'd5, 6'h2A));
        issue(wr, 1'b1, 32'h0000_0003, 2'd0);
        expect_out($sformatf("R5 type0 dev%0d", dev), 3'd2, wr ? 4'b1011 : 4'b1010,
                   type0_ad(dev, 3'd5, 6'h2A), exp_be_n(2'd0, 2'd3));
        release_out();
    endtask

    task automatic t_type1();
        write_reg(12'h1F8, car(1'b1, 8'h01, 5'd30, 3'd7, 6'h3F));
        issue(1'b0, 1'b1, 32'h0000_0000, 2'd1);
        expect_out("R6 type1 bus1", 3'd3, 4'b1010,
                   {8'h00, 8'h01, 5'd30, 3'd7, 6'h3F, 2'b01}, exp_be_n(2'd1, 2'd0));
        release_out();
        write_reg(12'h1F8, car(1'b1, 8'hA5, 5'd9, 3'd2, 6'h11));
        issue(1'b1, 1'b1, 32'h0000_0000, 2'd3);
        expect_out("R6 type1 busA5", 3'd3, 4'b1011,
                   {8'h00, 8'hA5, 5'd9, 3'd2, 6'h11, 2'b01}, 4'b0000);
        release_out();
    endtask

    task automatic t_special();
        write_reg(12'h1F8, car(1'b1, 8'h00, 5'd31, 3'd0, 6'd0));
        issue(1'b0, 1'b1, 32'h0000_0000, 2'd2);
        expect_out("R7 int ack", 3'd4, 4'b0000, 32'h0, 4'b0000);
        release_out();
        write_reg(12'h1F8, car(1'b1, 8'h07, 5'd31, 3'd0, 6'd0));
        issue(1'b1, 1'b1, 32'h0000_0000, 2'd2);
        expect_out("R7 special cycle", 3'd4, 4'b0001, 32'h0, 4'b0000);
        release_out();
    endtask

    task automatic t_wrong_offset();
        write_reg(12'h1F8, car(1'b0, 8'h00, 5'd0, 3'd0, 6'd0));
        write_reg(12'h1FC, car(1'b1, 8'h00, 5'd1, 3'd0, 6'd0));
        write_reg(12'h0F8, car(1'b1, 8'h00, 5'd1, 3'd0, 6'd0));
        issue(1'b0, 1'b1, 32'h0000_0040, 2'd2);
        expect_out("R2 other offset ignored", 3'd1, 4'b0010, 32'h0000_0040, 4'b0000);
        release_out();
    endtask

    task automatic t_lanes();
        write_reg(12'h1F8, 32'h0);
        for (int s = 0; s < 3; s++) begin
            for (int a = 0; a < 4; a++) begin
                issue(1'b0, 1'b1, 32'h100 + 32'(a), 2'(s));
                check($sformatf("R8 lanes size%0d addr%0d", s, a), 64'(out_cbe_n),
                      64'(exp_be_n(2'(s), 2'(a))));
                release_out();
            end
        end
    endtask

    task automatic t_backpressure();
        write_reg(12'h1F8, car(1'b1, 8'h00, 5'd4, 3'd1, 6'd2));
        issue(1'b0, 1'b1, 32'h0, 2'd2);
        req_valid = 1'b1; req_io_win = 1'b0; req_addr = 32'hDEAD_BEE0;
        repeat (3) @(negedge clk);
        check("R9 ready low while pending", 64'(req_ready), 64'd0);
        expect_out("R9 held under backpressure", 3'd2, 4'b1010,
                   type0_ad(5'd4, 3'd1, 6'd2), 4'b0000);
        req_valid = 1'b0;
        release_out();
        check("R9 second request not taken", 64'(out_valid), 64'd0);
    endtask

    task automatic t_write_pending();
        write_reg(12'h1F8, car(1'b1, 8'h00, 5'd2, 3'd0, 6'd1));
        issue(1'b1, 1'b1, 32'h0, 2'd2);
        write_reg(12'h1F8, car(1'b0, 8'h00, 5'd2, 3'd0, 6'd1));
        expect_out("R10 pending unchanged", 3'd2, 4'b1011, type0_ad(5'd2, 3'd0, 6'd1), 4'b0000);
        release_out();
        issue(1'b1, 1'b1, 32'h0000_0088, 2'd2);
        expect_out("R10 next uses new value", 3'd1, 4'b0011, 32'h0000_0088, 4'b0000);
        release_out();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_memory();
        t_io_disabled();
        t_type0(5'd0, 1'b0);
        t_type0(5'd20, 1'b1);
        t_type0(5'd21, 1'b0);
        t_type0(5'd30, 1'b1);
        t_type1();
        t_special();
        t_wrong_offset();
        t_lanes();
        t_backpressure();
        t_write_pending();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule